// File: doc/BRIEF.md
# Program Counter and Circular Return Stack

This block holds the instruction address of a small microcontroller core with 14-bit instructions. It keeps a 13-bit program counter, an 8-entry return-address stack of 13-bit entries, and a byte-wide holding register that supplies the upper address bits whenever the counter is loaded from a narrower source. The core's sequencer drives one-cycle strobes for each kind of address change. These are a plain advance, an absolute jump, a subroutine call, a write of the ALU result into the counter's low byte, a return, and an interrupt acknowledge. The block answers with the new address on the next clock edge.

The holding register is written by software as an ordinary data byte. It is never loaded from the counter, and stack traffic does not touch it. Jumps and calls carry only an 11-bit target, so the two page bits above the target come from the holding register. A low-byte write takes all five upper bits from it. The stack is a ring with a hidden pointer. Overflow silently overwrites the oldest entry, and underflow silently re-reads old entries. No status signal reports either case.

Top module: `pc_stack_unit`

## Requirements
- R1: After reset the counter is 0x0000, the holding register reads 0x00, and the stack pointer is at slot 0 with every slot cleared, so a return issued before any push loads 0x0000.
- R2: An advance strobe loads counter+1, and the 13-bit value wraps from 0x1FFF to 0x0000.
- R3: A jump loads bits [10:0] with the 11-bit target and bits [12:11] with holding-register bits [4:3]. It does not touch the stack.
- R4: A call loads the counter exactly as a jump does and pushes counter+1 as the return address.
- R5: A low-byte write loads bits [7:0] with the written byte and bits [12:8] with holding-register bits [4:0]. The low-byte output always equals counter bits [7:0].
- R6: A return strobe pops the stack and loads the popped 13-bit value into the counter.
- R7: An interrupt acknowledge pushes the current counter value and loads 0x0004.
- R8: The stack is a ring of 8 slots. A push writes the slot at the pointer and then increments the pointer modulo 8. A pop decrements the pointer modulo 8 and then reads that slot. So the ninth push overwrites the first, and the ninth of nine pops returns the same value as the first.
- R9: A write to the holding register stores the low five bits of the byte, and bits [7:5] read as 0. The new value takes effect on the next cycle, so a counter load in the same cycle uses the old value. Pushes, pops and counter loads never change it.
- R10: When several strobes are active at once, only one acts, in this priority order: interrupt acknowledge, return, call, jump, low-byte write, advance. With no strobe active the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Absolute jump to tgt_i |
| call_i | input | 1 | Subroutine call to tgt_i, pushing the return address |
| tgt_i | input | 11 | Jump or call target |
| lowr_i | input | 1 | Write lowr_val_i into the counter's low byte |
| lowr_val_i | input | 8 | ALU result for a low-byte write |
| ret_i | input | 1 | Pop the stack into the counter (all return kinds) |
| irq_ack_i | input | 1 | Interrupt acknowledge: push and vector |
| lat_we_i | input | 1 | Write the holding register |
| lat_wdata_i | input | 8 | Data byte for the holding register |
| pc_o | output | 13 | Current program counter |
| pcl_o | output | 8 | Readable low byte of the counter |
| lat_o | output | 8 | Readable holding register, bits [7:5] zero |

## Verification
Several behaviours are checked by assertions on every cycle. These are the vector load after an acknowledge, the counter load from the stack head on a return, the advance and the hold, and the page-bit merge on a jump. The assertions also confirm that the holding register changes only on its own write, that a push and a pop are never issued together, and that a slot popped right after a push returns the pushed value. Other behaviours can only be shown by the bench's scenarios, because they depend on long histories. These are the ring overwrite after nine pushes, the re-read after nine pops, the 0x1FFF wrap, the cleared slots seen by a return issued straight after reset, and the same-cycle ordering between a holding-register write and a load that uses it.

// File: rtl/pcsu_pkg.sv
package pcsu_pkg;

    // One action is selected per cycle, highest priority first.
    typedef enum logic [2:0] {
        ACT_IRQ  = 3'd0,
        ACT_RET  = 3'd1,
        ACT_CALL = 3'd2,
        ACT_JUMP = 3'd3,
        ACT_LOWR = 3'd4,
        ACT_ADV  = 3'd5,
        ACT_HOLD = 3'd6
    } pcsu_act_e;

endpackage

// File: rtl/pcsu_hilatch.sv
module pcsu_hilatch #(
    parameter int DW   = 8,
    parameter int HI_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [HI_W-1:0] hi_o,
    output logic [DW-1:0]   lat_o
);

    typedef struct packed {
        logic [HI_W-1:0] v;
    } lat_t;

    lat_t st_d, st_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i[DW-1:HI_W];

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.v = wdata_i[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_o  = st_q.v;
    assign lat_o = {{(DW-HI_W){1'b0}}, st_q.v};

    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(lat_o)); // R9
    AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> lat_o[HI_W-1:0] == $past(wdata_i[HI_W-1:0])); // R9

endmodule

// File: rtl/pcsu_rstack.sv
module pcsu_rstack #(
    parameter int AW    = 13,
    parameter int DEPTH = 8   // power of two: the pointer wraps naturally
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] head_o
);

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]           sp;
        logic [DEPTH-1:0][AW-1:0]   mem;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.sp] = wdata_i;
            st_d.sp           = st_q.sp + PTR_W'(1);
        end else if (pop_i) begin
            st_d.sp           = st_q.sp - PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Slot a pop would read: one below the pointer.
    assign head_o = st_q.mem[st_q.sp - PTR_W'(1)];

    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R10
    AST_PUSH_THEN_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(push_i) && pop_i |-> head_o == $past(wdata_i)); // R8

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
    parameter int PC_W    = 13,
    parameter int LIT_W   = 11,
    parameter int DW      = 8,
    parameter int DEPTH   = 8,
    parameter int IRQ_VEC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             jump_i,
    input  logic             call_i,
    input  logic [LIT_W-1:0] tgt_i,
    input  logic             lowr_i,
    input  logic [DW-1:0]    lowr_val_i,
    input  logic             ret_i,
    input  logic             irq_ack_i,
    input  logic             lat_we_i,
    input  logic [DW-1:0]    lat_wdata_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [DW-1:0]    pcl_o,
    output logic [DW-1:0]    lat_o
);
    import pcsu_pkg::*;

    localparam int HI_W = PC_W - DW;     // bits above the low byte
    localparam int PG_W = PC_W - LIT_W;  // page bits above a jump target

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_st_t;

    pc_st_t          st_d, st_q;
    pcsu_act_e       act;
    logic [HI_W-1:0] hi;
    logic [PC_W-1:0] stk_head;
    logic [PC_W-1:0] push_data;
    logic            push, pop;
    logic [PC_W-1:0] pc_inc;

    pcsu_hilatch #(.DW(DW), .HI_W(HI_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lat_we_i),
        .wdata_i (lat_wdata_i),
        .hi_o    (hi),
        .lat_o   (lat_o)
    );

    pcsu_rstack #(.AW(PC_W), .DEPTH(DEPTH)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (push_data),
        .head_o  (stk_head)
    );

    // Priority select of the single action for this cycle.
    always_comb begin
        if      (irq_ack_i) act = ACT_IRQ;
        else if (ret_i)     act = ACT_RET;
        else if (call_i)    act = ACT_CALL;
        else if (jump_i)    act = ACT_JUMP;
        else if (lowr_i)    act = ACT_LOWR;
        else if (adv_i)     act = ACT_ADV;
        else                act = ACT_HOLD;
    end

    assign pc_inc = st_q.pc + PC_W'(1);

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = pc_inc;
        case (act)
            ACT_IRQ: begin
                push      = 1'b1;
                push_data = st_q.pc;
                st_d.pc   = PC_W'(IRQ_VEC);
            end
            ACT_RET: begin
                pop     = 1'b1;
                st_d.pc = stk_head;
            end
            ACT_CALL: begin
                push    = 1'b1;
                st_d.pc = {hi[HI_W-1 -: PG_W], tgt_i};
            end
            ACT_JUMP: st_d.pc = {hi[HI_W-1 -: PG_W], tgt_i};
            ACT_LOWR: st_d.pc = {hi, lowr_val_i};
            ACT_ADV:  st_d.pc = pc_inc;
            default:  st_d    = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o  = st_q.pc;
    assign pcl_o = st_q.pc[DW-1:0];

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_i |=> pc_o == PC_W'(IRQ_VEC)); // R7
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && !irq_ack_i |=> pc_o == $past(stk_head)); // R6
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !irq_ack_i && !ret_i && !call_i && !jump_i && !lowr_i
        |=> pc_o == PC_W'($past(pc_o) + PC_W'(1))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i && !irq_ack_i && !ret_i && !call_i && !jump_i && !lowr_i
        |=> $stable(pc_o)); // R10
    AST_JUMP_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i && !irq_ack_i && !ret_i && !call_i
        |=> pc_o == {$past(lat_o[HI_W-1 -: PG_W]), $past(tgt_i)}); // R3

endmodule

// File: tb/pc_stack_unit_tb.sv
module pc_stack_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_i = 0, jump_i = 0, call_i = 0, lowr_i = 0, ret_i = 0, irq_ack_i = 0, lat_we_i = 0;
    logic [10:0] tgt_i = '0;
    logic [7:0]  lowr_val_i = '0, lat_wdata_i = '0;
    logic [12:0] pc_o;
    logic [7:0]  pcl_o, lat_o;

    int tests = 0, fails = 0;
    bit done = 0;

    // Behavioural reference state
    int m_pc, m_lat, m_sp;
    int m_stk[8];

    always #10 clk = ~clk;

    pc_stack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jump_i(jump_i), .call_i(call_i),
        .tgt_i(tgt_i), .lowr_i(lowr_i), .lowr_val_i(lowr_val_i), .ret_i(ret_i),
        .irq_ack_i(irq_ack_i), .lat_we_i(lat_we_i), .lat_wdata_i(lat_wdata_i),
        .pc_o(pc_o), .pcl_o(pcl_o), .lat_o(lat_o)
    );

    task automatic compare(input string tag);
        tests++;
        if (pc_o !== 13'(m_pc) || pcl_o !== 8'(m_pc & 8'hFF) || lat_o !== 8'(m_lat)) begin
            fails++;
            $display("FAIL %s: pc=%h pcl=%h lat=%h expected pc=%h pcl=%h lat=%h",
                     tag, pc_o, pcl_o, lat_o, 13'(m_pc), 8'(m_pc & 8'hFF), 8'(m_lat));
        end
    endtask

    // Drive one cycle of strobes, advance the model, compare after the edge.
    task automatic step(input bit irq, input bit ret, input bit call, input bit jmp,
                        input bit lw, input bit adv, input int tgt, input int lv,
                        input bit lwe, input int lwd, input string tag);
        int old_lat;
        irq_ack_i = irq; ret_i = ret; call_i = call; jump_i = jmp;
        lowr_i = lw; adv_i = adv; tgt_i = 11'(tgt); lowr_val_i = 8'(lv);
        lat_we_i = lwe; lat_wdata_i = 8'(lwd);
        old_lat = m_lat;
        if (irq) begin
            m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = 4;
        end else if (ret) begin
            m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
        end else if (call) begin
            m_stk[m_sp] = (m_pc + 1) & 'h1FFF; m_sp = (m_sp + 1) % 8;
            m_pc = (((old_lat >> 3) & 3) << 11) | (tgt & 'h7FF);
        end else if (jmp) begin
            m_pc = (((old_lat >> 3) & 3) << 11) | (tgt & 'h7FF);
        end else if (lw) begin
            m_pc = ((old_lat & 'h1F) << 8) | (lv & 'hFF);
        end else if (adv) begin
            m_pc = (m_pc + 1) & 'h1FFF;
        end
        if (lwe) m_lat = lwd & 'h1F;
        @(posedge clk);
        @(negedge clk);
        irq_ack_i = 0; ret_i = 0; call_i = 0; jump_i = 0; lowr_i = 0; adv_i = 0; lat_we_i = 0;
        compare(tag);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
        end
    end

    initial begin
        m_pc = 0; m_lat = 0; m_sp = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");
        // R1: a return before any push reads a cleared slot
        step(0,1,0,0,0,0, 0,0, 0,0, "R1 pop after reset");
        // R2: sequential advance
        for (int i = 0; i < 3; i++) step(0,0,0,0,0,1, 0,0, 0,0, "R2 advance");
        // R9: holding register write masks bits 7:5
        step(0,0,0,0,0,0, 0,0, 1,'hFF, "R9 latch write");
        // R5 then R2: load 0x1FFF via low byte, advance wraps to 0
        step(0,0,0,0,1,0, 0,'hFF, 0,0, "R5 low write");
        step(0,0,0,0,0,1, 0,0, 0,0, "R2 wrap");
        // R3: jump merges latch bits 4:3
        step(0,0,0,1,0,0, 'h5A5,0, 0,0, "R3 jump");
        // R9: same-cycle latch write and jump uses the old latch value
        step(0,0,0,1,0,0, 'h123,0, 1,'h08, "R9 latch vs jump");
        step(0,0,0,1,0,0, 'h123,0, 0,0, "R3 jump new page");
        // R4 / R6: call and return
        step(0,0,1,0,0,0, 'h7FF,0, 0,0, "R4 call");
        step(0,0,0,0,0,1, 0,0, 0,0, "R2 advance in sub");
        step(0,1,0,0,0,0, 0,0, 0,0, "R6 return");
        // R7: interrupt acknowledge then return
        step(1,0,0,0,0,0, 0,0, 0,0, "R7 irq ack");
        step(0,1,0,0,0,0, 0,0, 0,0, "R6 return from irq");
        // R10: priority cases
        step(0,0,1,0,0,0, 'h040,0, 0,0, "R10 setup call");
        step(1,1,1,1,1,1, 'h300,'h55, 0,0, "R10 irq wins");
        step(0,1,1,1,1,1, 'h300,'h55, 0,0, "R10 ret beats call");
        step(0,0,0,1,1,1, 'h2AA,'h55, 0,0, "R10 jump beats low write");
        step(0,0,0,0,1,1, 0,'h3C, 0,0, "R10 low write beats advance");
        step(0,0,0,0,0,0, 0,0, 0,0, "R10 idle hold");
        // R9: latch untouched by stack traffic
        step(0,0,1,0,0,0, 'h100,0, 0,0, "R9 latch across call");
        step(0,1,0,0,0,0, 0,0, 0,0, "R9 latch across return");
        // R8: nine calls then nine returns on the ring
        for (int i = 0; i < 9; i++) step(0,0,1,0,0,0, 'h010 * (i + 1),0, 0,0, "R8 ring push");
        for (int i = 0; i < 9; i++) step(0,1,0,0,0,0, 0,0, 0,0, "R8 ring pop");
        done = 1;
        summary();
    end

endmodule